// File: doc/BRIEF.md
# Interrupt Enable and Pending Gate

This block decides when a small microcontroller core should start an interrupt. It handles two sources. The first is an external pin that requests service while it is held low. The second is an overflow pulse from the timer/counter. Each source has its own enable bit. The enable bits are set and cleared by four single-byte opcodes, which the core presents with a strobe. The block raises one interrupt-start request toward the core sequencer, together with a one-bit source identifier. The sequencer answers with an acknowledge when it takes the interrupt.

A timer overflow always sets a timer flag, whether or not the timer interrupt is enabled. The flag stays set until software reads it through a flag-test strobe. An overflow raises a pending timer request only while the timer interrupt is enabled. The pending request is dropped in two cases: when the sequencer acknowledges a timer interrupt, or when the timer-disable opcode executes. Overflows keep arriving, and the flag keeps tracking them, while the timer interrupt is disabled; only the request to the core is held back.

Top module: `irq_gate`

## Requirements
- R1: After reset both enable bits are clear, no timer request is pending, the timer flag is 0 and `int_req` is 0.
- R2: With `op_valid` high, byte 0x05 sets the external enable, 0x15 clears it, 0x25 sets the timer enable and 0x35 clears it. Each change takes effect at the next clock edge. Any other byte, or any byte with `op_valid` low, leaves both enables unchanged.
- R3: While the external enable is clear, a low level on `ext_irq_n` never raises `int_req` with `int_src` = 0.
- R4: While the external enable is set, a low level on `ext_irq_n` raises `int_req` with `int_src` = 0 two clock edges later, through a two-stage synchronizer. The request holds for as long as the pin stays low.
- R5: A `tmr_ovf` pulse while the timer enable is set makes a timer request pending. `int_req` then rises with `int_src` = 1 after the next edge, unless the external source is active.
- R6: The timer-disable opcode clears a pending timer request at the next edge. This also holds when an overflow arrives in the same cycle.
- R7: Every `tmr_ovf` pulse sets `tmr_flag` at the next edge, whatever the state of the timer enable.
- R8: `tmr_flag` is cleared only by `flag_rd`, and an acknowledge does not clear it. When `flag_rd` and `tmr_ovf` arrive in the same cycle, the flag stays set.
- R9: When the external source is active and a timer request is pending, `int_src` is 0 (the external source has priority).
- R10: `int_ack` while `int_req` is high and `int_src` is 1 clears the pending timer request. If `tmr_ovf` arrives with the enable set in that same cycle, the request stays pending. An acknowledge while `int_src` is 0 leaves the timer request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode strobe |
| op_byte | input | 8 | Opcode byte presented with the strobe |
| ext_irq_n | input | 1 | External interrupt pin, active low, asynchronous |
| tmr_ovf | input | 1 | One-cycle timer/counter overflow pulse |
| flag_rd | input | 1 | Flag-test read strobe; clears the timer flag |
| int_ack | input | 1 | Sequencer acknowledge of the current request |
| int_req | output | 1 | Interrupt-start request |
| int_src | output | 1 | Source of the request: 0 external, 1 timer |
| tmr_flag | output | 1 | Sticky timer overflow flag |

## Verification
Three pairs of events can land in the same cycle:
- An overflow can arrive together with the timer-disable opcode.
- An overflow can arrive together with an acknowledge of the timer request.
- An overflow can arrive together with the flag-test read.

The bench forces each pair directly, and random stimulus with dense strobes produces many more of them. A cycle model in the bench judges each outcome from the stated winners. Disable beats overflow, a new overflow beats the acknowledge, and a new overflow beats the flag read. The outcome is seen on `int_req`, `int_src` and `tmr_flag` in the cycle after the edge.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_EXT_ON,
    CMD_EXT_OFF,
    CMD_TMR_ON,
    CMD_TMR_OFF
  } irq_cmd_e;

  localparam logic SRC_EXT = 1'b0;
  localparam logic SRC_TMR = 1'b1;

  // sticky flag: a fresh overflow wins over a read that clears
  function automatic logic flag_next(input logic cur, input logic ovf, input logic rd);
    return ovf | (cur & ~rd);
  endfunction

  // pending request: disable beats set, set beats acknowledge
  function automatic logic pend_next(input logic cur, input logic set_en,
                                     input logic dis, input logic ack);
    logic nxt;
    if (dis)         nxt = 1'b0;
    else if (set_en) nxt = 1'b1;
    else if (ack)    nxt = 1'b0;
    else             nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/irq_opdec.sv
module irq_opdec
  import irq_gate_pkg::*;
#(
  parameter int unsigned OP_W = 8,
  parameter logic [OP_W-1:0] OP_EXT_ON  = 8'h05,
  parameter logic [OP_W-1:0] OP_EXT_OFF = 8'h15,
  parameter logic [OP_W-1:0] OP_TMR_ON  = 8'h25,
  parameter logic [OP_W-1:0] OP_TMR_OFF = 8'h35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_byte,
  output logic            ext_en,
  output logic            tmr_en,
  output logic            tmr_dis_evt
);

  irq_cmd_e cmd;

  always_comb begin
    cmd = CMD_NONE;
    if (op_valid) begin
      if (op_byte == OP_EXT_ON)       cmd = CMD_EXT_ON;
      else if (op_byte == OP_EXT_OFF) cmd = CMD_EXT_OFF;
      else if (op_byte == OP_TMR_ON)  cmd = CMD_TMR_ON;
      else if (op_byte == OP_TMR_OFF) cmd = CMD_TMR_OFF;
    end
  end

  assign tmr_dis_evt = (cmd == CMD_TMR_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en <= 1'b0;
      tmr_en <= 1'b0;
    end else begin
      case (cmd)
        CMD_EXT_ON:  ext_en <= 1'b1;
        CMD_EXT_OFF: ext_en <= 1'b0;
        CMD_TMR_ON:  tmr_en <= 1'b1;
        CMD_TMR_OFF: tmr_en <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level
);

  logic [STAGES-1:0] sh;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= ~pin_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[g] <= 1'b0;
          else        sh[g] <= sh[g-1];
        end
      end
    end
  endgenerate

  assign level = sh[STAGES-1];

endmodule

// File: rtl/irq_tmr_track.sv
module irq_tmr_track
  import irq_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic tmr_en,
  input  logic dis_evt,
  input  logic flag_rd,
  input  logic ack_tmr,
  output logic pend,
  output logic flag
);

  logic set_en;
  assign set_en = ovf & tmr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      flag <= 1'b0;
    end else begin
      pend <= pend_next(pend, set_en, dis_evt, ack_tmr);
      flag <= flag_next(flag, ovf, flag_rd);
    end
  end

endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_gate_pkg::*;
(
  input  logic ext_active,
  input  logic tmr_pend,
  output logic req,
  output logic src
);

  always_comb begin
    req = ext_active | tmr_pend;
    src = ext_active ? SRC_EXT : SRC_TMR;
  end

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned OP_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [OP_W-1:0] OP_EXT_ON  = 8'h05,
  parameter logic [OP_W-1:0] OP_EXT_OFF = 8'h15,
  parameter logic [OP_W-1:0] OP_TMR_ON  = 8'h25,
  parameter logic [OP_W-1:0] OP_TMR_OFF = 8'h35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_byte,
  input  logic            ext_irq_n,
  input  logic            tmr_ovf,
  input  logic            flag_rd,
  input  logic            int_ack,
  output logic            int_req,
  output logic            int_src,
  output logic            tmr_flag
);

  // named internal events, visible to the bound checker
  logic ext_en_q;
  logic tmr_en_q;
  logic tmr_dis_evt;
  logic ext_lvl;
  logic ext_active;
  logic tmr_pend_q;
  logic ack_tmr_evt;

  irq_opdec #(
    .OP_W(OP_W), .OP_EXT_ON(OP_EXT_ON), .OP_EXT_OFF(OP_EXT_OFF),
    .OP_TMR_ON(OP_TMR_ON), .OP_TMR_OFF(OP_TMR_OFF)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .ext_en(ext_en_q), .tmr_en(tmr_en_q), .tmr_dis_evt(tmr_dis_evt)
  );

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_irq_n), .level(ext_lvl)
  );

  assign ext_active  = ext_en_q & ext_lvl;
  assign ack_tmr_evt = int_ack & int_req & (int_src == SRC_TMR);

  irq_tmr_track u_tmr (
    .clk(clk), .rst_n(rst_n), .ovf(tmr_ovf), .tmr_en(tmr_en_q),
    .dis_evt(tmr_dis_evt), .flag_rd(flag_rd), .ack_tmr(ack_tmr_evt),
    .pend(tmr_pend_q), .flag(tmr_flag)
  );

  irq_arb u_arb (
    .ext_active(ext_active), .tmr_pend(tmr_pend_q),
    .req(int_req), .src(int_src)
  );

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic tmr_ovf,
  input logic flag_rd,
  input logic int_ack,
  input logic int_req,
  input logic int_src,
  input logic tmr_flag,
  input logic ext_en_q,
  input logic tmr_en_q,
  input logic tmr_dis_evt,
  input logic ext_active,
  input logic tmr_pend_q
);

  a_r3_ext_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_q |-> !(int_req && int_src == 1'b0));

  a_r5_ovf_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf && tmr_en_q && !tmr_dis_evt) |=> (int_req && tmr_pend_q));

  a_r6_dis_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_dis_evt |=> !tmr_pend_q);

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_flag);

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_ovf && !flag_rd) |=> $stable(tmr_flag));

  a_r9_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |-> (int_req && int_src == 1'b0));

  a_r10_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req && int_src && !tmr_ovf) |=> !tmr_pend_q);

endmodule

bind irq_gate irq_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .flag_rd(flag_rd),
  .int_ack(int_ack), .int_req(int_req), .int_src(int_src),
  .tmr_flag(tmr_flag), .ext_en_q(ext_en_q), .tmr_en_q(tmr_en_q),
  .tmr_dis_evt(tmr_dis_evt), .ext_active(ext_active),
  .tmr_pend_q(tmr_pend_q)
);

// File: tb/irq_gate_test.sv
`timescale 1ns/1ps
module irq_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       ext_irq_n = 1'b1;
  logic       tmr_ovf = 1'b0;
  logic       flag_rd = 1'b0;
  logic       int_ack = 1'b0;
  logic       int_req, int_src, tmr_flag;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic m_ext_en = 0, m_tmr_en = 0, m_pend = 0, m_flag = 0, m_s0 = 0, m_s1 = 0;

  always #2 clk = ~clk;

  irq_gate uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf), .flag_rd(flag_rd),
    .int_ack(int_ack), .int_req(int_req), .int_src(int_src),
    .tmr_flag(tmr_flag)
  );

  function automatic logic exp_req();
    return (m_ext_en & m_s1) | m_pend;
  endfunction

  function automatic logic exp_src();
    return (m_ext_en & m_s1) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(int_req, exp_req(), {tag, " int_req"});
    if (exp_req()) check(int_src, exp_src(), {tag, " int_src"});
    check(tmr_flag, m_flag, {tag, " tmr_flag"});
  endtask

  // apply inputs, advance one edge, update model, compare at negedge
  task automatic step(input logic ov, input logic [7:0] ob, input logic pin,
                      input logic ovf, input logic rd, input logic ack,
                      input string tag);
    logic dis, setp, ackt;
    op_valid = ov; op_byte = ob; ext_irq_n = pin;
    tmr_ovf = ovf; flag_rd = rd; int_ack = ack;
    @(posedge clk);
    dis  = ov && ob == 8'h35;
    setp = ovf && m_tmr_en;
    ackt = ack && exp_req() && exp_src();
    m_pend = dis ? 1'b0 : setp ? 1'b1 : ackt ? 1'b0 : m_pend;
    m_flag = ovf | (m_flag & ~rd);
    m_s1 = m_s0; m_s0 = ~pin;
    if (ov) begin
      if (ob == 8'h05) m_ext_en = 1'b1;
      if (ob == 8'h15) m_ext_en = 1'b0;
      if (ob == 8'h25) m_tmr_en = 1'b1;
      if (ob == 8'h35) m_tmr_en = 1'b0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(int_req, 1'b0, "R1 int_req");
    check(tmr_flag, 1'b0, "R1 tmr_flag");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R3: pin low with external disabled
    repeat (4) step(0, 8'h00, 0, 0, 0, 0, "R3 disabled pin");
    // R2/R4: enable, request two edges later
    step(1, 8'h05, 0, 0, 0, 0, "R2 ext enable");
    step(0, 8'h00, 0, 0, 0, 0, "R4 pin low held");
    step(0, 8'h00, 1, 0, 0, 0, "R4 pin released");
    step(0, 8'h00, 1, 0, 0, 0, "R4 sync drain");
    step(0, 8'h00, 1, 0, 0, 0, "R4 idle");
    // R2: foreign byte and unstrobed code leave enables alone
    step(1, 8'h15, 1, 0, 0, 0, "R2 ext disable");
    step(1, 8'h45, 0, 0, 0, 0, "R2 foreign byte");
    step(0, 8'h05, 0, 0, 0, 0, "R2 no strobe");
    repeat (2) step(0, 8'h00, 0, 0, 0, 0, "R2 enables unchanged");
    step(0, 8'h00, 1, 0, 0, 0, "R2 idle");
    repeat (2) step(0, 8'h00, 1, 0, 0, 0, "R2 pin drain");

    // R7: overflow with timer disabled sets flag only
    step(0, 8'h00, 1, 1, 0, 0, "R7 ovf while disabled");
    // R8: read clears, ack does not, ovf+read keeps
    step(0, 8'h00, 1, 0, 0, 1, "R8 ack keeps flag");
    step(0, 8'h00, 1, 1, 1, 0, "R8 ovf with read");
    step(0, 8'h00, 1, 0, 1, 0, "R8 read clears");
    // R5/R6
    step(1, 8'h25, 1, 0, 0, 0, "R2 tmr enable");
    step(0, 8'h00, 1, 1, 0, 0, "R5 ovf pends");
    step(1, 8'h35, 1, 0, 0, 0, "R6 disable clears");
    step(1, 8'h25, 1, 0, 0, 0, "R2 tmr re-enable");
    step(1, 8'h35, 1, 1, 0, 0, "R6 disable with ovf");
    // R10
    step(1, 8'h25, 1, 0, 0, 0, "R10 setup");
    step(0, 8'h00, 1, 1, 0, 0, "R10 pend");
    step(0, 8'h00, 1, 0, 0, 1, "R10 ack clears");
    step(0, 8'h00, 1, 1, 0, 0, "R10 pend again");
    step(0, 8'h00, 1, 1, 0, 1, "R10 ack with ovf keeps");
    // R9: external priority, ack on ext leaves timer pending
    step(1, 8'h05, 0, 0, 0, 0, "R9 ext enable");
    step(0, 8'h00, 0, 0, 0, 0, "R9 sync");
    step(0, 8'h00, 0, 0, 0, 0, "R9 both active");
    step(0, 8'h00, 1, 0, 0, 1, "R10 ack on ext");
    step(0, 8'h00, 1, 0, 0, 0, "R10 sync drain");
    step(0, 8'h00, 1, 0, 0, 0, "R10 timer still pending");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] b;
      int k;
      k = $urandom_range(0, 4);
      b = (k == 0) ? 8'h05 : (k == 1) ? 8'h15 : (k == 2) ? 8'h25 :
          (k == 3) ? 8'h35 : 8'($urandom);
      step(($urandom_range(0, 9) < 3), b, ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 3) == 0), "R5 R7 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule